// File: doc/BRIEF.md
# Serial flash host controller

This block is the host side of a four-wire serial link to a small flash memory. A client hands it one request at a time over a valid/ready handshake. Each request holds an operation, a 24-bit address, a data byte and a byte count. The controller builds the matching frame. It drives chip select, the serial clock and the serial output line, captures the returned line, and passes every fetched byte back with a one-cycle strobe.

Program, erase and abort frames start a self-timed operation inside the memory. After each of these frames the controller issues status frames on its own, each under a separate chip-select pulse, until the ready bit in the status byte reads 1. It then signals completion. If the ready bit does not appear within a set number of polls, it raises an error flag.

All link timing is derived from nanosecond parameters and the system clock frequency. These limits are the clock half-period, chip-select setup and hold around clock activity, and the minimum chip-select high time.

Top module: `sflash_host`

## Requirements
- R1: Op code 0 (read) sends 0xFF, the address high byte first, then 16 clock periods with SI low. It then shifts in `req_len_i` bytes. Each byte appears on `rdata_o` with a one-cycle `rvalid_o`, in the order received.
- R2: Op code 1 (program) sends 0x10, the three address bytes, the data byte and a 0x00 filler byte in one chip-select pulse.
- R3: Op code 2 (erase) sends 0x20, the three address bytes, 0xD0 and a 0x00 filler byte in one chip-select pulse.
- R4: Op code 3 (status) sends 0x9F and shifts in one byte, which is returned on `rdata_o` with `rvalid_o`.
- R5: Op codes 4 and 5 (abort) send 0x10 or 0x20 respectively, the three address bytes, 0xFF in place of the fifth byte, and a 0x00 filler byte.
- R6: After a frame from op 1, 2, 4 or 5, the controller sends 0x9F status frames, each under its own chip-select pulse. It stops at the first status byte whose bit 0 is 1. It then pulses `done_o`. Every request ends with a `done_o` pulse, and no status byte from a poll reaches `rdata_o`.
- R7: If `MAX_POLLS` polls all return bit 0 = 0, `err_o` rises together with `done_o`. It stays high until the next request is accepted.
- R8: The serial clock idles low. SI changes only while it is low, and SO is sampled on its rising edge. Each high and each low phase lasts at least the derived half-period: at the defaults, 5 cycles of a 100 MHz clock.
- R9: The serial clock toggles only while chip select is low. Chip select falls at least the setup time before the first rising edge and rises at least the hold time after the last falling edge: 40 cycles each at the defaults.
- R10: Chip select stays high for at least the derived idle time, 25 cycles at the defaults, between any two frames.
- R11: Out of reset, chip select is high, the clock low, `req_ready_o` high, and `done_o`, `rvalid_o` and `err_o` low. `req_ready_o` is high only while no request is in progress.
- R12: Op codes 6 and 7 are accepted and answered with a `done_o` pulse on the next cycle, with no chip-select activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request taken when valid |
| req_op_i | input | 3 | Operation code (see R1 to R5, R12) |
| req_addr_i | input | 24 | Memory address |
| req_wdata_i | input | 8 | Byte to program |
| req_len_i | input | LEN_W | Number of bytes to read |
| rdata_o | output | 8 | Returned byte |
| rvalid_o | output | 1 | One-cycle strobe for `rdata_o` |
| done_o | output | 1 | One-cycle pulse when a request completes |
| err_o | output | 1 | Poll timeout flag |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| si_o | output | 1 | Serial data to memory |
| so_i | input | 1 | Serial data from memory |

## Verification
A returned byte is strobed one cycle after the high phase of its eighth clock ends. `done_o` follows one cycle after the last chip-select idle gap, and for an unknown op code it follows on the cycle after acceptance. The bench drives and samples only on falling system-clock edges. It collects strobed bytes and waits for `done_o` in per-cycle loops rather than at fixed offsets. A memory model in the bench decodes the frames bit by bit from the link pins. Run lengths of clock phases, setup, hold and idle gaps are measured in whole cycles and compared with limits the bench derives from the nanosecond figures.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam logic [2:0] OP_READ      = 3'd0;
  localparam logic [2:0] OP_PROG      = 3'd1;
  localparam logic [2:0] OP_ERASE     = 3'd2;
  localparam logic [2:0] OP_STAT      = 3'd3;
  localparam logic [2:0] OP_ABT_PROG  = 3'd4;
  localparam logic [2:0] OP_ABT_ERASE = 3'd5;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_PROG    = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_STAT    = 8'h9F;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CANCEL  = 8'hFF;
  localparam logic [7:0] FILL_BYTE   = 8'h00;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP} state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/sflash_byte_xfer.sv
module sflash_byte_xfer #(
  parameter int unsigned HALF_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       so_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       si_o
);
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [HW-1:0] hcnt;
  logic          busy, ph, done_q;
  logic [2:0]    bitc;
  logic [7:0]    txs, rxs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt <= '0; busy <= 1'b0; ph <= 1'b0; done_q <= 1'b0;
      bitc <= '0; txs <= '0; rxs <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1; ph <= 1'b0; hcnt <= '0; bitc <= '0; txs <= tx_i;
        end
      end else if (hcnt == HW'(HALF_CYC - 1)) begin
        hcnt <= '0;
        if (!ph) begin
          ph  <= 1'b1;
          rxs <= {rxs[6:0], so_i};      // sample on rising clock
        end else begin
          ph <= 1'b0;                   // falling clock: advance data
          if (bitc == 3'd7) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bitc <= bitc + 3'd1;
            txs  <= {txs[6:0], 1'b0};
          end
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign sck_o  = busy & ph;
  assign si_o   = txs[7];
  assign rx_o   = rxs;
  assign done_o = done_q;
endmodule

// File: rtl/sflash_frame_sel.sv
module sflash_frame_sel
  import sflash_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  localparam int unsigned IDX_W = LEN_W + 1
) (
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [23:0]      addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [7:0]       tx_o,
  output logic             last_o,
  output logic             rx_o
);
  logic [7:0]       addr_b [3];
  logic [7:0]       opc, fifth;
  logic [IDX_W-1:0] total;

  for (genvar g = 0; g < 3; g++) begin : g_addr
    assign addr_b[g] = addr_i[23-8*g -: 8];
  end

  always_comb begin
    opc   = CMD_STAT;
    fifth = FILL_BYTE;
    total = IDX_W'(6);
    case (op_i)
      OP_READ:      begin opc = CMD_READ;  total = IDX_W'(len_i) + IDX_W'(6); end
      OP_PROG:      begin opc = CMD_PROG;  fifth = wdata_i;     end
      OP_ERASE:     begin opc = CMD_ERASE; fifth = CMD_CONFIRM; end
      OP_ABT_PROG:  begin opc = CMD_PROG;  fifth = CMD_CANCEL;  end
      OP_ABT_ERASE: begin opc = CMD_ERASE; fifth = CMD_CANCEL;  end
      default:      begin opc = CMD_STAT;  total = IDX_W'(2);   end
    endcase

    tx_o = FILL_BYTE;
    if (idx_i == '0)              tx_o = opc;
    else if (idx_i <= IDX_W'(3))  tx_o = addr_b[idx_i[1:0] - 2'd1];
    else if (idx_i == IDX_W'(4))  tx_o = fifth;

    last_o = (idx_i == total - IDX_W'(1));
    if (op_i == OP_READ) rx_o = (idx_i >= IDX_W'(6));
    else                 rx_o = (op_i == OP_STAT) && (idx_i == IDX_W'(1));
  end
endmodule

// File: rtl/sflash_host.sv
module sflash_host
  import sflash_pkg::*;
#(
  parameter int unsigned SYS_MHZ      = 100,
  parameter int unsigned SCK_MAX_MHZ  = 10,
  parameter int unsigned SCK_PHASE_NS = 45,
  parameter int unsigned CS_SETUP_NS  = 400,
  parameter int unsigned CS_HOLD_NS   = 400,
  parameter int unsigned CS_IDLE_NS   = 250,
  parameter int unsigned MAX_POLLS    = 8,
  parameter int unsigned LEN_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [7:0]       req_wdata_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic [7:0]       rdata_o,
  output logic             rvalid_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             si_o,
  input  logic             so_i
);
  localparam int unsigned HALF_F   = (SYS_MHZ + 2*SCK_MAX_MHZ - 1) / (2*SCK_MAX_MHZ);
  localparam int unsigned HALF_T   = ns2cyc(SCK_PHASE_NS, SYS_MHZ);
  localparam int unsigned HALF_M   = (HALF_F > HALF_T) ? HALF_F : HALF_T;
  localparam int unsigned HALF_CYC = (HALF_M > 0) ? HALF_M : 1;
  localparam int unsigned CSS_T    = ns2cyc(CS_SETUP_NS, SYS_MHZ);
  localparam int unsigned CSH_T    = ns2cyc(CS_HOLD_NS, SYS_MHZ);
  localparam int unsigned CPH_T    = ns2cyc(CS_IDLE_NS, SYS_MHZ);
  localparam int unsigned CSS_CYC  = (CSS_T > 0) ? CSS_T : 1;
  localparam int unsigned CSH_CYC  = (CSH_T > 0) ? CSH_T : 1;
  localparam int unsigned CPH_CYC  = (CPH_T > 0) ? CPH_T : 1;
  localparam int unsigned TMAX1    = (CSS_CYC > CSH_CYC) ? CSS_CYC : CSH_CYC;
  localparam int unsigned TMAX     = (TMAX1 > CPH_CYC) ? TMAX1 : CPH_CYC;
  localparam int unsigned TMR_W    = $clog2(TMAX + 1);
  localparam int unsigned IDX_W    = LEN_W + 1;
  localparam int unsigned PW       = $clog2(MAX_POLLS + 1);

  state_e           state;
  logic [2:0]       op_q;
  logic [23:0]      addr_q;
  logic [7:0]       wdata_q, rdata_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx;
  logic [TMR_W-1:0] tmr;
  logic [PW-1:0]    npoll;
  logic             kick, polling, pend, ready_bit, done_q, err_q, rvalid_q, cs_n_q;
  logic             x_done, f_last, f_rx;
  logic [7:0]       x_rx, f_tx;

  sflash_frame_sel #(.LEN_W(LEN_W)) u_sel (
    .op_i(op_q), .idx_i(idx), .addr_i(addr_q), .wdata_i(wdata_q), .len_i(len_q),
    .tx_o(f_tx), .last_o(f_last), .rx_o(f_rx)
  );

  sflash_byte_xfer #(.HALF_CYC(HALF_CYC)) u_xfer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(kick), .tx_i(f_tx), .so_i(so_i),
    .done_o(x_done), .rx_o(x_rx), .sck_o(sck_o), .si_o(si_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; op_q <= '0; addr_q <= '0; wdata_q <= '0; len_q <= '0;
      idx <= '0; tmr <= '0; npoll <= '0; kick <= 1'b0; polling <= 1'b0; pend <= 1'b0;
      ready_bit <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; rvalid_q <= 1'b0;
      rdata_q <= '0; cs_n_q <= 1'b1;
    end else begin
      kick     <= 1'b0;
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid_i) begin
          err_q   <= 1'b0;
          op_q    <= req_op_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          len_q   <= req_len_i;
          idx     <= '0;
          tmr     <= '0;
          npoll   <= '0;
          polling <= 1'b0;
          pend    <= (req_op_i == OP_PROG) || (req_op_i == OP_ERASE) ||
                     (req_op_i == OP_ABT_PROG) || (req_op_i == OP_ABT_ERASE);
          if (req_op_i > OP_ABT_ERASE) done_q <= 1'b1;
          else begin
            cs_n_q <= 1'b0;
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: if (tmr == TMR_W'(CSS_CYC - 1)) begin
          tmr <= '0; kick <= 1'b1; state <= ST_SHIFT;
        end else tmr <= tmr + TMR_W'(1);
        ST_SHIFT: if (x_done) begin
          if (f_rx) begin
            if (polling) ready_bit <= x_rx[0];
            else begin rvalid_q <= 1'b1; rdata_q <= x_rx; end
          end
          if (f_last) state <= ST_HOLD;
          else begin idx <= idx + IDX_W'(1); kick <= 1'b1; end
        end
        ST_HOLD: if (tmr == TMR_W'(CSH_CYC - 1)) begin
          tmr <= '0; cs_n_q <= 1'b1; state <= ST_GAP;
        end else tmr <= tmr + TMR_W'(1);
        ST_GAP: if (tmr == TMR_W'(CPH_CYC - 1)) begin
          tmr <= '0;
          if (polling) begin
            if (ready_bit) begin
              done_q <= 1'b1; state <= ST_IDLE;
            end else if (npoll == PW'(MAX_POLLS - 1)) begin
              err_q <= 1'b1; done_q <= 1'b1; state <= ST_IDLE;
            end else begin
              npoll <= npoll + PW'(1); idx <= '0; cs_n_q <= 1'b0; state <= ST_SETUP;
            end
          end else if (pend) begin
            polling <= 1'b1; op_q <= OP_STAT; idx <= '0; cs_n_q <= 1'b0; state <= ST_SETUP;
          end else begin
            done_q <= 1'b1; state <= ST_IDLE;
          end
        end else tmr <= tmr + TMR_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state == ST_IDLE);
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign cs_n_o      = cs_n_q;
endmodule

// File: rtl/sflash_host_chk.sv
module sflash_host_chk #(
  parameter int unsigned HALF_CYC = 1,
  parameter int unsigned CPH_CYC  = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_o,
  input logic sck_o,
  input logic si_o,
  input logic req_ready_o,
  input logic rvalid_o,
  input logic done_o,
  input logic err_o
);
  localparam int unsigned TOPV = (HALF_CYC > CPH_CYC) ? HALF_CYC : CPH_CYC;
  localparam int unsigned CW   = $clog2(TOPV + 2);

  logic [CW-1:0] lvl_cnt, hi_cnt;
  logic          sck_q, cs_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_cnt <= CW'(TOPV); hi_cnt <= CW'(TOPV);
      sck_q <= 1'b0; cs_q <= 1'b1; err_q <= 1'b0;
    end else begin
      sck_q <= sck_o;
      cs_q  <= cs_n_o;
      err_q <= err_o;
      if (sck_o != sck_q)          lvl_cnt <= CW'(1);
      else if (lvl_cnt < CW'(TOPV)) lvl_cnt <= lvl_cnt + CW'(1);
      if (cs_n_o != cs_q)          hi_cnt <= CW'(1);
      else if (hi_cnt < CW'(TOPV)) hi_cnt <= hi_cnt + CW'(1);
    end
  end

  assert_sck_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_n_o);
  assert_si_stable_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && sck_q) |-> $stable(si_o));
  assert_sck_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && (sck_o != sck_q)) |-> (lvl_cnt >= CW'(HALF_CYC)));
  assert_cs_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && cs_q) |-> (hi_cnt >= CW'(CPH_CYC)));
  assert_ready_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (cs_n_o && !sck_o));
  assert_err_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_q) |-> done_o);
  assert_rvalid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

bind sflash_host sflash_host_chk #(.HALF_CYC(HALF_CYC), .CPH_CYC(CPH_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_o(cs_n_o), .sck_o(sck_o), .si_o(si_o),
  .req_ready_o(req_ready_o), .rvalid_o(rvalid_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_sflash_host.sv
module tb_sflash_host;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_EXP   = 5;   // max(ceil(45ns/10ns), 100MHz/(2*10MHz))
  localparam int CSS_EXP    = 40;
  localparam int CSH_EXP    = 40;
  localparam int CPH_EXP    = 25;
  localparam int NVEC       = 8;
  // {op, addr, wdata, len, busy replies}
  localparam logic [46:0] VEC [NVEC] = '{
    {3'd0, 24'h012345, 8'h00, 8'd4, 4'd0},
    {3'd1, 24'h00ABCD, 8'h5A, 8'd0, 4'd3},
    {3'd2, 24'h000700, 8'h00, 8'd0, 4'd0},
    {3'd3, 24'h000000, 8'h00, 8'd0, 4'd0},
    {3'd4, 24'h000010, 8'h00, 8'd0, 4'd1},
    {3'd5, 24'h00FF00, 8'h00, 8'd0, 4'd2},
    {3'd0, 24'h00FFFE, 8'h00, 8'd1, 4'd0},
    {3'd1, 24'h123456, 8'h00, 8'd0, 4'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_wdata = '0, req_len = '0;
  logic [7:0] rdata;
  logic rvalid, done, err, cs_n, sck, si;
  logic so = 1'b0;

  int n_checks = 0, n_err = 0;

  sflash_host dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_len_i(req_len),
    .rdata_o(rdata), .rvalid_o(rvalid), .done_o(done), .err_o(err),
    .cs_n_o(cs_n), .sck_o(sck), .si_o(si), .so_i(so)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] cur [16];
  logic [7:0] first_fb [16];
  logic [7:0] shin = '0, ob;
  int bitn = 0, bytn = 0, busy_left = 0, busy_cfg = 0;
  int frm_cnt = 0, poll_cnt = 0, cs_falls = 0, first_len = 0;

  function automatic logic [7:0] slv_out(int n);
    if (cur[0] == 8'hFF && n >= 6) return (cur[3] + 8'(n - 6)) ^ 8'h3C;
    if (cur[0] == 8'h9F && n == 1) return (busy_left > 0) ? 8'hA4 : 8'hA5;
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin bitn = 0; bytn = 0; cs_falls++; so = 1'b0; end
  always @(posedge sck) if (!cs_n) begin
    shin = {shin[6:0], si};
    bitn++;
    if (bitn == 8) begin
      if (bytn < 16) cur[bytn] = shin;
      bytn++;
      bitn = 0;
    end
  end
  always @(negedge sck) if (!cs_n) begin ob = slv_out(bytn); so = ob[7-bitn]; end
  always @(posedge cs_n) begin
    if (frm_cnt == 0) begin
      first_len = bytn;
      for (int i = 0; i < 16; i++) first_fb[i] = cur[i];
    end
    frm_cnt++;
    if (bytn >= 1 && cur[0] == 8'h9F) begin
      poll_cnt++;
      if (busy_left > 0) busy_left--;
    end else if (bytn == 6 && (cur[0] == 8'h10 || cur[0] == 8'h20)) busy_left = busy_cfg;
  end

  // ---------------- read data and timing monitors ----------------
  logic [7:0] rd [16];
  int rd_n = 0;
  logic cs_p = 1'b1, sck_p = 1'b0, si_p = 1'b0, first_rise = 1'b0;
  int c_high = 100000, c_lowfr = 0, c_sf = 0, c_hi = 0;
  int min_hi = 100000, min_lo = 100000, min_css = 100000, min_csh = 100000, min_cph = 100000;
  int si_bad = 0, sck_out = 0;

  always @(negedge clk) if (rst_n) begin
    if (rvalid && rd_n < 16) begin rd[rd_n] = rdata; rd_n++; end
    if (cs_n != cs_p) begin
      if (!cs_n) begin
        if (c_high < min_cph) min_cph = c_high;
        c_lowfr = 0; first_rise = 1'b1;
      end else begin
        if (c_sf < min_csh) min_csh = c_sf;
        c_high = 0;
      end
    end
    if (sck && !sck_p) begin
      if (first_rise) begin
        if (c_lowfr < min_css) min_css = c_lowfr;
        first_rise = 1'b0;
      end else if (c_sf < min_lo) min_lo = c_sf;
      c_hi = 0;
    end
    if (!sck && sck_p) begin
      if (c_hi < min_hi) min_hi = c_hi;
      c_sf = 0;
    end
    if (sck && sck_p && si != si_p) si_bad++;
    if (sck && cs_n) sck_out++;
    c_high++; c_lowfr++; c_sf++; c_hi++;
    cs_p = cs_n; sck_p = sck; si_p = si;
  end

  // ---------------- stimulus ----------------
  bit got_done, got_err;

  task automatic run_req(input logic [2:0] op, input logic [23:0] a, input logic [7:0] d,
                         input logic [7:0] len, input int busy);
    int cyc;
    busy_cfg = busy; busy_left = 0; frm_cnt = 0; poll_cnt = 0; rd_n = 0; cs_falls = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_len = len; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (op <= 3'd5) check(req_ready == 1'b0, "R11 ready while busy", req_ready, 0);
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    got_done = done;
    got_err  = err;
  endtask

  function automatic logic [7:0] exp_byte(logic [2:0] op, logic [23:0] a, logic [7:0] d, int k);
    case (k)
      0: case (op)
           3'd0: return 8'hFF;
           3'd1, 3'd4: return 8'h10;
           3'd2, 3'd5: return 8'h20;
           default: return 8'h9F;
         endcase
      1: return a[23:16];
      2: return a[15:8];
      3: return a[7:0];
      4: case (op)
           3'd1: return d;
           3'd2: return 8'hD0;
           3'd4, 3'd5: return 8'hFF;
           default: return 8'h00;
         endcase
      default: return 8'h00;
    endcase
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_err++;
    $display("FAIL R11 watchdog actual=hung expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cs_n == 1'b1 && sck == 1'b0, "R11 reset link idle", {cs_n, sck}, 2'b10);
    check(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    check(done == 0 && rvalid == 0 && err == 0, "R11 reset flags", {done, rvalid, err}, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] op; logic [23:0] a; logic [7:0] d, len; int busy;
      int exp_len, exp_polls, bad_k;
      string tag;
      {op, a, d, len} = VEC[v][46:4];
      busy = int'(VEC[v][3:0]);
      case (op)
        3'd0: tag = "R1"; 3'd1: tag = "R2"; 3'd2: tag = "R3";
        3'd3: tag = "R4"; default: tag = "R5";
      endcase
      run_req(op, a, d, len, busy);
      exp_len   = (op == 3'd0) ? 6 + int'(len) : (op == 3'd3) ? 2 : 6;
      exp_polls = (op == 3'd0) ? 0 : (op == 3'd3) ? 1 : busy + 1;
      check(got_done, {"R6 done ", tag}, got_done, 1);
      check(first_len == exp_len, {tag, " frame length"}, first_len, exp_len);
      bad_k = -1;
      for (int k = 0; k < exp_len && k < 6; k++)
        if (k < 16 && bad_k < 0 && first_fb[k] !== exp_byte(op, a, d, k)) bad_k = k;
      if (bad_k >= 0) check(1'b0, {tag, " frame byte"}, first_fb[bad_k], exp_byte(op, a, d, bad_k));
      else            check(1'b1, {tag, " frame byte"}, 0, 0);
      check(poll_cnt == exp_polls, "R6 poll count", poll_cnt, exp_polls);
      check(got_err == 1'b0, "R7 no error", got_err, 0);
      if (op == 3'd0) begin
        check(rd_n == int'(len), "R1 byte count", rd_n, len);
        for (int k = 0; k < int'(len) && k < rd_n; k++)
          check(rd[k] == ((a[7:0] + 8'(k)) ^ 8'h3C), "R1 read data", rd[k], (a[7:0] + 8'(k)) ^ 8'h3C);
      end else if (op == 3'd3) begin
        check(rd_n == 1 && rd[0] == 8'hA5, "R4 status byte", rd[0], 8'hA5);
      end else begin
        check(rd_n == 0, "R6 poll bytes not returned", rd_n, 0);
      end
    end

    // R7 poll timeout: busy for more polls than MAX_POLLS (8)
    run_req(3'd1, 24'h000042, 8'h77, 8'd0, 15);
    check(got_done && got_err, "R7 timeout error with done", {got_done, got_err}, 2'b11);
    check(poll_cnt == 8, "R7 poll limit", poll_cnt, 8);
    repeat (3) @(negedge clk);
    check(err == 1'b1, "R7 error held", err, 1);
    run_req(3'd3, 24'h0, 8'h0, 8'd0, 0);
    check(got_err == 1'b0, "R7 error cleared by next request", got_err, 0);

    // R12 undefined op codes
    for (int u = 6; u < 8; u++) begin
      run_req(3'(u), 24'h000001, 8'h00, 8'd2, 0);
      check(got_done, "R12 done for undefined op", got_done, 1);
      check(cs_falls == 0, "R12 no chip select", cs_falls, 0);
    end
    repeat (5) @(negedge clk);

    // Link timing
    check(min_hi >= HALF_EXP, "R8 clock high phase", min_hi, HALF_EXP);
    check(min_lo >= HALF_EXP, "R8 clock low phase", min_lo, HALF_EXP);
    check(si_bad == 0, "R8 SI steady while clock high", si_bad, 0);
    check(min_css >= CSS_EXP, "R9 chip select setup", min_css, CSS_EXP);
    check(min_csh >= CSH_EXP, "R9 chip select hold", min_csh, CSH_EXP);
    check(sck_out == 0, "R9 clock outside frame", sck_out, 0);
    check(min_cph >= CPH_EXP, "R10 chip select idle", min_cph, CPH_EXP);

    finish_run();
  end
endmodule